// File: doc/BRIEF.md
# Multi-Core Nonce Partition Controller

This block runs one mining work unit on several parallel hash cores at once and collects their results into one reporting channel. A host-side loader presents a 256-bit midstate and the tail data words together with a one-cycle load pulse. The block captures them and sends the same values to every core. Each core gets a fixed slice of the nonce space: the top nonce bits carry the core's index, and a shared low counter sweeps the remaining bits once per cycle.

Each core raises a match flag a fixed number of cycles after it was given the nonce that produced a difficulty-1 share. A match means the top 32 bits of the double hash are zero. The block subtracts that latency to recover the nonce that produced the hash. It queues matches from all cores in ascending core order and presents them one at a time on a result register. Each result is held until the host acknowledges it. The block does not compare results against the real network target; the host does that filtering. A sticky wrap flag tells the host when the low counter has covered its whole range, so the host can supply new work before the cores repeat nonces.

Top module: `nonce_partition_ctrl`

## Requirements
- R1: On a load pulse the midstate and tail inputs are captured, and from the next cycle they drive every core unchanged until the next load.
- R2: The top log2(N_CORES) bits of core i's nonce always equal i.
- R3: The low NONCE_W-log2(N_CORES) bits of all core nonces are equal. They are zero in the first cycle after a load and increase by one each cycle after that, wrapping modulo their width. Before the first load they stay at zero.
- R4: A match flag seen in cycle m reports, for that core, the nonce issued in cycle m-MATCH_LAT, taken modulo the low-bit width.
- R5: A match flag is discarded when no nonce of the current work was issued MATCH_LAT cycles earlier. This covers every cycle before the first load and the first MATCH_LAT cycles after any load.
- R6: Matches from several cores in the same cycle are presented in ascending core index, with the lowest index first.
- R7: result_valid_o rises in the cycle after an accepted match. It stays high, with result_nonce_o stable, until result_ack_i is sampled high. The next queued result appears in the following cycle.
- R8: wrap_o rises in the cycle in which the low nonce bits return from all ones to zero, and it stays high until the next load.
- R9: A load empties the result queue and clears wrap_o. Both are low in the cycle after the load.
- R10: When the queue (QUEUE_DEPTH entries) has no room, further matches are dropped and entries already queued are delivered intact.
- R11: After reset, result_valid_o and wrap_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | One-cycle pulse that captures new work |
| midstate_i | input | 256 | Midstate of the new work |
| tail_i | input | TAIL_W | Tail data words of the new work |
| core_midstate_o | output | 256 | Midstate sent to all cores |
| core_tail_o | output | TAIL_W | Tail words sent to all cores |
| core_nonce_o | output | N_CORES*NONCE_W | Nonce for each core, core i in slice i |
| core_match_i | input | N_CORES | Match flag from each core |
| result_nonce_o | output | NONCE_W | Nonce at the head of the result queue |
| result_valid_o | output | 1 | A result is being presented |
| result_ack_i | input | 1 | Host takes the presented result |
| wrap_o | output | 1 | Low nonce bits have wrapped under the current work |

## Verification
The assertions assume two things about the inputs. First, load_i is a clean single-cycle pulse. Second, result_ack_i is only raised while a result is presented, so a held result never changes without an acknowledgement. The bench raises the acknowledgement only after it has seen valid high. It pulses load exactly once per scenario. Core match flags are driven as a model of cores with the configured latency, with each flag timed relative to the cycle of the load.

// File: rtl/nonce_pkg.sv
package nonce_pkg;
  localparam int unsigned MID_W = 256;

  function automatic int unsigned idx_bits(input int unsigned n);
    return (n <= 1) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/nonce_span_counter.sv
module nonce_span_counter #(
  parameter int LOW_W     = 30,
  parameter int MATCH_LAT = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  output logic [LOW_W-1:0] cnt_o,
  output logic             run_o,
  output logic             mature_o,
  output logic             wrap_o
);
  logic [LOW_W-1:0]     cnt_q;
  logic                 run_q, wrap_q;
  logic [MATCH_LAT-1:0] age_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      run_q  <= 1'b0;
      wrap_q <= 1'b0;
      age_q  <= '0;
    end else if (load_i) begin
      cnt_q  <= '0;
      run_q  <= 1'b1;
      wrap_q <= 1'b0;
      age_q  <= '0;
    end else begin
      // age_q[k] marks that a nonce of this work was issued k+1 cycles ago
      age_q <= MATCH_LAT'({age_q, run_q});
      if (run_q) begin
        cnt_q <= cnt_q + 1'b1;
        if (&cnt_q) wrap_q <= 1'b1;
      end
    end
  end

  assign cnt_o    = cnt_q;
  assign run_o    = run_q;
  assign mature_o = age_q[MATCH_LAT-1];
  assign wrap_o   = wrap_q;
endmodule

// File: rtl/nonce_lane.sv
module nonce_lane #(
  parameter int NONCE_W   = 32,
  parameter int IDX_W     = 2,
  parameter int IDX       = 0,
  parameter int MATCH_LAT = 4
) (
  input  logic [NONCE_W-IDX_W-1:0] cnt_i,
  output logic [NONCE_W-1:0]       nonce_o,
  output logic [NONCE_W-1:0]       hit_nonce_o
);
  localparam int LOW_W = NONCE_W - IDX_W;
  localparam logic [IDX_W-1:0] TAG = IDX_W'(IDX);

  assign nonce_o     = {TAG, cnt_i};
  // modular subtraction recovers the nonce in flight MATCH_LAT cycles ago
  assign hit_nonce_o = {TAG, LOW_W'(cnt_i - LOW_W'(MATCH_LAT))};
endmodule

// File: rtl/share_queue.sv
module share_queue #(
  parameter int WIDTH = 32,
  parameter int PORTS = 4,
  parameter int DEPTH = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clear_i,
  input  logic [PORTS-1:0]   push_i,
  input  logic [PORTS*WIDTH-1:0] din_i,
  input  logic               pop_i,
  output logic [WIDTH-1:0]   dout_o,
  output logic               valid_o
);
  localparam int AW = (DEPTH <= 1) ? 1 : $clog2(DEPTH);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [AW-1:0]    wr_ptr_q, rd_ptr_q;
  logic [AW:0]      cnt_q;
  logic [PORTS-1:0] wr_en;
  logic [AW-1:0]    wr_addr [PORTS];
  logic [AW:0]      n_wr;
  logic             do_pop;

  // ascending port order fills consecutive slots; no room means drop
  always_comb begin
    int slot;
    slot = 0;
    for (int i = 0; i < PORTS; i++) begin
      wr_en[i]   = 1'b0;
      wr_addr[i] = '0;
      if (push_i[i] && (int'(cnt_q) + slot < DEPTH)) begin
        wr_en[i]   = 1'b1;
        wr_addr[i] = wr_ptr_q + AW'(slot);
        slot       = slot + 1;
      end
    end
    n_wr = (AW+1)'(slot);
  end

  assign do_pop = pop_i && (cnt_q != '0);

  always_ff @(posedge clk_i) begin
    for (int i = 0; i < PORTS; i++)
      if (wr_en[i] && !clear_i) mem_q[wr_addr[i]] <= din_i[i*WIDTH +: WIDTH];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else if (clear_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_q + AW'(n_wr);
      rd_ptr_q <= rd_ptr_q + AW'(do_pop);
      cnt_q    <= cnt_q + n_wr - (AW+1)'(do_pop);
    end
  end

  assign valid_o = (cnt_q != '0);
  assign dout_o  = mem_q[rd_ptr_q];
endmodule

// File: rtl/nonce_partition_ctrl.sv
module nonce_partition_ctrl
  import nonce_pkg::*;
#(
  parameter int N_CORES     = 4,
  parameter int NONCE_W     = 32,
  parameter int TAIL_W      = 96,
  parameter int MATCH_LAT   = 4,
  parameter int QUEUE_DEPTH = 4
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       load_i,
  input  logic [MID_W-1:0]           midstate_i,
  input  logic [TAIL_W-1:0]          tail_i,
  output logic [MID_W-1:0]           core_midstate_o,
  output logic [TAIL_W-1:0]          core_tail_o,
  output logic [N_CORES*NONCE_W-1:0] core_nonce_o,
  input  logic [N_CORES-1:0]         core_match_i,
  output logic [NONCE_W-1:0]         result_nonce_o,
  output logic                       result_valid_o,
  input  logic                       result_ack_i,
  output logic                       wrap_o
);
  localparam int IDX_W = idx_bits(N_CORES);
  localparam int LOW_W = NONCE_W - IDX_W;

  logic [MID_W-1:0]           mid_q;
  logic [TAIL_W-1:0]          tail_q;
  logic [LOW_W-1:0]           cnt;
  logic                       run, mature;
  logic [N_CORES-1:0]         accept;
  logic [N_CORES*NONCE_W-1:0] hit_nonce;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mid_q  <= '0;
      tail_q <= '0;
    end else if (load_i) begin
      mid_q  <= midstate_i;
      tail_q <= tail_i;
    end
  end

  assign core_midstate_o = mid_q;
  assign core_tail_o     = tail_q;

  nonce_span_counter #(.LOW_W(LOW_W), .MATCH_LAT(MATCH_LAT)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load_i),
    .cnt_o   (cnt),
    .run_o   (run),
    .mature_o(mature),
    .wrap_o  (wrap_o)
  );

  for (genvar g = 0; g < N_CORES; g++) begin : g_lane
    nonce_lane #(
      .NONCE_W(NONCE_W), .IDX_W(IDX_W), .IDX(g), .MATCH_LAT(MATCH_LAT)
    ) u_lane (
      .cnt_i      (cnt),
      .nonce_o    (core_nonce_o[g*NONCE_W +: NONCE_W]),
      .hit_nonce_o(hit_nonce[g*NONCE_W +: NONCE_W])
    );
  end

  // flags without an issued nonce of this work behind them are stale
  assign accept = core_match_i & {N_CORES{mature & ~load_i}};

  share_queue #(.WIDTH(NONCE_W), .PORTS(N_CORES), .DEPTH(QUEUE_DEPTH)) u_q (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clear_i(load_i),
    .push_i (accept),
    .din_i  (hit_nonce),
    .pop_i  (result_ack_i),
    .dout_o (result_nonce_o),
    .valid_o(result_valid_o)
  );
endmodule

// File: rtl/nonce_partition_chk.sv
module nonce_partition_chk #(
  parameter int N_CORES = 4,
  parameter int NONCE_W = 32,
  parameter int MID_W   = 256
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       load_i,
  input logic                       run,
  input logic [MID_W-1:0]           core_midstate_o,
  input logic [N_CORES*NONCE_W-1:0] core_nonce_o,
  input logic [NONCE_W-1:0]         result_nonce_o,
  input logic                       result_valid_o,
  input logic                       result_ack_i,
  input logic                       wrap_o
);
  localparam int IDX_W = (N_CORES <= 1) ? 1 : $clog2(N_CORES);
  localparam int LOW_W = NONCE_W - IDX_W;

  p_work_stable_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(core_midstate_o));

  for (genvar g = 0; g < N_CORES; g++) begin : g_tag
    p_top_bits_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      core_nonce_o[g*NONCE_W+NONCE_W-1 -: IDX_W] == IDX_W'(g));
  end

  p_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && !load_i) |=> core_nonce_o[LOW_W-1:0] == LOW_W'($past(core_nonce_o[LOW_W-1:0]) + 1'b1));

  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (result_valid_o && !result_ack_i && !load_i) |=> result_valid_o && $stable(result_nonce_o));

  p_wrap_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wrap_o && !load_i) |=> wrap_o);

  p_load_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> !result_valid_o && !wrap_o);
endmodule

bind nonce_partition_ctrl nonce_partition_chk #(
  .N_CORES(N_CORES), .NONCE_W(NONCE_W), .MID_W(nonce_pkg::MID_W)
) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .load_i         (load_i),
  .run            (run),
  .core_midstate_o(core_midstate_o),
  .core_nonce_o   (core_nonce_o),
  .result_nonce_o (result_nonce_o),
  .result_valid_o (result_valid_o),
  .result_ack_i   (result_ack_i),
  .wrap_o         (wrap_o)
);

// File: tb/sim_nonce_partition_ctrl.sv
`timescale 1ns/1ps
module sim_nonce_partition_ctrl;
  localparam int NC = 4, NW = 12, TW = 96, LAT = 3, QD = 4;
  localparam int LW = NW - 2;

  logic              clk_i = 1'b0, rst_ni = 1'b0, load_i = 1'b0, result_ack_i = 1'b0;
  logic [255:0]      midstate_i = '0;
  logic [TW-1:0]     tail_i = '0;
  logic [255:0]      core_midstate_o;
  logic [TW-1:0]     core_tail_o;
  logic [NC*NW-1:0]  core_nonce_o;
  logic [NC-1:0]     core_match_i = '0;
  logic [NW-1:0]     result_nonce_o;
  logic              result_valid_o, wrap_o;

  int n_chk = 0, n_bad = 0, cyc = 0;

  always #2.5 clk_i = ~clk_i;

  nonce_partition_ctrl #(.N_CORES(NC), .NONCE_W(NW), .TAIL_W(TW),
    .MATCH_LAT(LAT), .QUEUE_DEPTH(QD)) u0 (.*);

  task automatic chk(string req, logic [255:0] act, logic [255:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk_i);
    cyc += n;
  endtask

  function automatic logic [NW-1:0] nv(int core, int low);
    return {2'(core), LW'(low)};
  endfunction

  task automatic load(logic [255:0] m, logic [TW-1:0] t);
    load_i = 1'b1; midstate_i = m; tail_i = t;
    @(negedge clk_i);
    load_i = 1'b0; midstate_i = '0; tail_i = '0;
    cyc = 0;
  endtask

  task automatic pulse(logic [NC-1:0] m);
    core_match_i = m;
    step(1);
    core_match_i = '0;
  endtask

  task automatic ack();
    result_ack_i = 1'b1;
    step(1);
    result_ack_i = 1'b0;
  endtask

  task automatic t_reset();
    chk("R11 valid", 256'(result_valid_o), 0);
    chk("R11 wrap", 256'(wrap_o), 0);
    step(4);
    chk("R3 idle", 256'(core_nonce_o[2*NW +: NW]), 256'(nv(2, 0)));
    pulse(4'b0010);
    chk("R5 before load", 256'(result_valid_o), 0);
  endtask

  task automatic t_broadcast();
    load({8{32'hA5C3_0F11}}, {3{32'h1234_5678}});
    chk("R1 midstate", core_midstate_o, {8{32'hA5C3_0F11}});
    chk("R1 tail", 256'(core_tail_o), 256'({3{32'h1234_5678}}));
    for (int i = 0; i < NC; i++) chk("R2 R3 cycle0", 256'(core_nonce_o[i*NW +: NW]), 256'(nv(i, 0)));
    step(5);
    for (int i = 0; i < NC; i++) chk("R2 R3 cycle5", 256'(core_nonce_o[i*NW +: NW]), 256'(nv(i, 5)));
    chk("R1 held", core_midstate_o, {8{32'hA5C3_0F11}});
  endtask

  task automatic t_latency();
    load({8{32'h0000_0001}}, '1);
    step(1);
    pulse(4'b0010);                       // match at cycle 1: stale
    chk("R5 early", 256'(result_valid_o), 0);
    pulse(4'b0001);                       // cycle 2: still stale
    chk("R5 early2", 256'(result_valid_o), 0);
    pulse(4'b0100);                       // cycle 3: first valid
    chk("R5 boundary valid", 256'(result_valid_o), 1);
    chk("R4 boundary nonce", 256'(result_nonce_o), 256'(nv(2, 0)));
    ack();
    step(6 - cyc);
    pulse(4'b0010);                       // cycle 6
    chk("R4 nonce", 256'(result_nonce_o), 256'(nv(1, 3)));
    ack();
    chk("R7 drained", 256'(result_valid_o), 0);
  endtask

  task automatic t_multi();
    load({8{32'hDEAD_BEEF}}, '0);
    step(10);
    pulse(4'b1101);                       // cycle 10: cores 0,2,3
    chk("R6 first", 256'(result_nonce_o), 256'(nv(0, 7)));
    step(3);
    chk("R7 held valid", 256'(result_valid_o), 1);
    chk("R7 held nonce", 256'(result_nonce_o), 256'(nv(0, 7)));
    ack();
    chk("R6 second", 256'(result_nonce_o), 256'(nv(2, 7)));
    ack();
    chk("R6 third", 256'(result_nonce_o), 256'(nv(3, 7)));
    ack();
    chk("R7 empty", 256'(result_valid_o), 0);
  endtask

  task automatic t_full();
    load({8{32'h0BAD_F00D}}, '0);
    step(20);
    pulse(4'b1111);                       // cycle 20 fills queue
    pulse(4'b1111);                       // cycle 21 dropped
    for (int i = 0; i < NC; i++) begin
      chk("R10 kept", 256'(result_nonce_o), 256'(nv(i, 17)));
      ack();
    end
    chk("R10 dropped", 256'(result_valid_o), 0);
  endtask

  task automatic t_wrap();
    load({8{32'h7777_0000}}, '0);
    step(1023);
    chk("R8 before", 256'(wrap_o), 0);
    step(1);
    chk("R3 wrapped", 256'(core_nonce_o[3*NW +: NW]), 256'(nv(3, 0)));
    chk("R8 rise", 256'(wrap_o), 1);
    pulse(4'b1000);                       // cycle 1024 (low 0): issued at low 1021
    chk("R4 across wrap", 256'(result_nonce_o), 256'(nv(3, 1021)));
    step(5);
    chk("R8 sticky", 256'(wrap_o), 1);
    load({8{32'h1111_2222}}, {3{32'hCAFE_0000}});
    chk("R9 queue", 256'(result_valid_o), 0);
    chk("R9 wrap", 256'(wrap_o), 0);
    chk("R1 reload", 256'(core_tail_o), 256'({3{32'hCAFE_0000}}));
  endtask

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_broadcast();
    t_latency();
    t_multi();
    t_full();
    t_wrap();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule